// File: doc/BRIEF.md
# Two-Channel Serial Audio Word Receiver

This block sits at the digital entry of a stereo audio converter. It takes the three serial wires a source drives (a bit clock, a left/right frame clock and one data line) and turns each stereo frame into a pair of parallel two's-complement words with a one-cycle strobe. Everything runs in the bit-clock domain: the bit clock is the block clock `clk`, and the frame clock and data line are sampled on its rising edge.

One static pin picks the framing. With `fmt_i2s` low, the frame is MSB-justified: the most significant bit sits in the first slot after the frame clock changes, and frame clock high marks the left channel. With `fmt_i2s` high, the framing is I2S: the most significant bit comes one slot later, and frame clock low marks the left channel. Internally the I2S case is handled by delaying the frame clock by one slot, so the word assembler sees a single framing. The assembler is a three-state machine. `ST_SYNC` is entered at reset and waits for the first frame-clock edge, and it leaves on that edge (transition *lock*). `ST_DATA` collects bits. It moves to `ST_PAD` when the last bit of a word arrives (transition *word full*), or restarts itself on an early frame-clock edge (transition *cut short*). `ST_PAD` ignores the remaining slots of a half-frame and returns to `ST_DATA` on the next frame-clock edge (transition *next half*). A pairing stage holds the left word and releases both words together when the matching right word completes.

Top module: `sai_rx`

## Requirements
- R1: While `rst_n` is low, `valid_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: With `fmt_i2s` = 0, the bit sampled on the first rising `clk` edge at which `lrclk` differs from its value on the previous edge is bit 23 (the MSB) of a new word, and `lrclk` = 1 during that half-frame means left, `lrclk` = 0 means right.
- R3: With `fmt_i2s` = 1, bit 23 of a new word is sampled one rising edge after the first edge at which `lrclk` has changed, and `lrclk` = 0 means left, `lrclk` = 1 means right. With 24 slots per half, the LSB of one word is taken from the first slot of the next half-frame.
- R4: Words are 24-bit two's complement, sent MSB first, one bit per rising edge of `clk`; bit 23 of `left_o`/`right_o` is the first bit received.
- R5: Data in slots after the 24th slot of a word (slot 0 being the MSB) has no effect on the outputs.
- R6: When a frame-clock edge arrives before all 24 bits of a word have been received, the word is completed at once with its missing LSBs as 0. A sender that supplies 16 or 20 bits followed by zeros gives words with the same zero LSBs.
- R7: `valid_o` is a pulse of exactly one cycle, raised once per left/right pair after the right word's last bit, and `left_o`/`right_o` carry that pair while it is high.
- R8: `left_o` and `right_o` change only in a cycle where `valid_o` is high. A right word not preceded by a left word since the last pulse or reset produces no pulse.
- R9: Any rate of at least 24 slots per half-frame (48 per frame) is received correctly, including exactly 24 and the common 32.
- R10: The half-frame that is in progress when reset is released is discarded, because its start was not seen. Capture begins at the first frame-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all capture on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s | input | 1 | Framing select: 0 MSB-justified, 1 I2S |
| lrclk | input | 1 | Left/right frame clock |
| sdata | input | 1 | Serial data line |
| left_o | output | WIDTH | Left word of the last completed pair |
| right_o | output | WIDTH | Right word of the last completed pair |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The properties assume that every half-frame lasts at least two slots, so that two word completions can never fall on adjacent cycles, and that `fmt_i2s` changes only while reset is held. The stimulus keeps within both assumptions: each scenario starts with a reset that sets the format, and the shortest half-frame driven is 20 slots, which is used for the cut-short case. The frame clock and data are changed only on falling clock edges, so every sampled bit is settled at the rising edge that captures it.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

    // Word assembler states
    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,   // waiting for the first frame-clock edge after reset
        ST_DATA = 2'd1,   // collecting bits of a word
        ST_PAD  = 2'd2    // word full, ignoring remaining slots
    } asm_state_t;

endpackage

// File: rtl/sai_frame_edge.sv
module sai_frame_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fmt_i2s,
    input  logic lrclk,
    output logic frame_edge,
    output logic chan_right
);

    localparam int WARM_W   = 2;
    localparam int WARM_MAX = 2;

    logic              lr_q;
    logic              lr_q2;
    logic [WARM_W-1:0] warm;
    logic              cur_lr;
    logic              prev_lr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q  <= 1'b0;
            lr_q2 <= 1'b0;
            warm  <= '0;
        end else begin
            lr_q  <= lrclk;
            lr_q2 <= lr_q;
            if (warm != WARM_W'(WARM_MAX)) begin
                warm <= warm + 1'b1;
            end
        end
    end

    // I2S is treated as left-justified framing with the frame clock one slot late
    always_comb begin
        cur_lr     = fmt_i2s ? lr_q  : lrclk;
        prev_lr    = fmt_i2s ? lr_q2 : lr_q;
        frame_edge = (warm == WARM_W'(WARM_MAX)) && (cur_lr != prev_lr);
        chan_right = fmt_i2s ? cur_lr : ~cur_lr;
    end

endmodule

// File: rtl/sai_word_asm.sv
module sai_word_asm #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_edge,
    input  logic             chan_right,
    input  logic             sdata,
    output logic             word_done,
    output logic             word_right,
    output logic [WIDTH-1:0] word
);
    import sai_rx_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);

    asm_state_t     state, state_nx;
    logic [WIDTH-1:0] sh;
    logic [WIDTH-1:0] sh_ins;
    logic [CW-1:0]    cnt;
    logic             cur_right;
    logic             last_bit;

    assign last_bit = (cnt == CW'(WIDTH - 1));

    // Shift image with the current bit placed at its position
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            sh_ins[i] = (CW'(WIDTH - 1 - i) == cnt) ? sdata : sh[i];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SYNC;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SYNC: state_nx = frame_edge ? ST_DATA : ST_SYNC;
            ST_DATA: begin
                if (frame_edge) begin
                    state_nx = ST_DATA;
                end else if (last_bit) begin
                    state_nx = ST_PAD;
                end else begin
                    state_nx = ST_DATA;
                end
            end
            ST_PAD:  state_nx = frame_edge ? ST_DATA : ST_PAD;
            default: state_nx = ST_SYNC;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            cnt        <= '0;
            cur_right  <= 1'b0;
            word_done  <= 1'b0;
            word_right <= 1'b0;
            word       <= '0;
        end else begin
            word_done <= 1'b0;
            if (frame_edge) begin
                if (state == ST_DATA) begin
                    // cut short: unreceived LSBs stay zero
                    word_done  <= 1'b1;
                    word_right <= cur_right;
                    word       <= sh;
                end
                sh        <= {sdata, {(WIDTH-1){1'b0}}};
                cnt       <= CW'(1);
                cur_right <= chan_right;
            end else if (state == ST_DATA) begin
                if (last_bit) begin
                    word_done  <= 1'b1;
                    word_right <= cur_right;
                    word       <= sh_ins;
                end
                sh  <= sh_ins;
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sai_pair_out.sv
module sai_pair_out #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_done,
    input  logic             word_right,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] left_o,
    output logic [WIDTH-1:0] right_o,
    output logic             valid_o
);

    logic [WIDTH-1:0] left_hold;
    logic             have_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_done) begin
                if (!word_right) begin
                    left_hold <= word;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_o    <= left_hold;
                    right_o   <= word;
                    valid_o   <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sai_rx.sv
module sai_rx #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_i2s,
    input  logic             lrclk,
    input  logic             sdata,
    output logic [WIDTH-1:0] left_o,
    output logic [WIDTH-1:0] right_o,
    output logic             valid_o
);

    logic             f_edge;
    logic             f_right;
    logic             w_done;
    logic             w_right;
    logic [WIDTH-1:0] w_word;

    sai_frame_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i2s    (fmt_i2s),
        .lrclk      (lrclk),
        .frame_edge (f_edge),
        .chan_right (f_right)
    );

    sai_word_asm #(.WIDTH(WIDTH)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_edge (f_edge),
        .chan_right (f_right),
        .sdata      (sdata),
        .word_done  (w_done),
        .word_right (w_right),
        .word       (w_word)
    );

    sai_pair_out #(.WIDTH(WIDTH)) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (w_done),
        .word_right (w_right),
        .word       (w_word),
        .left_o     (left_o),
        .right_o    (right_o),
        .valid_o    (valid_o)
    );

endmodule

// File: rtl/sai_rx_chk.sv
module sai_rx_chk #(
    parameter int WIDTH = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] left_o,
    input logic [WIDTH-1:0] right_o,
    input logic             valid_o,
    input logic             w_done,
    input logic             w_right
);

    // R7: strobe lasts a single cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: outputs hold whenever no strobe is raised
    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R7: a strobe is always the consequence of a completed right word
    a_r7_valid_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(w_done && w_right));

    // R6: word completions are never on adjacent cycles
    a_r6_word_gap: assert property (@(posedge clk) disable iff (!rst_n)
        w_done |=> !w_done);

endmodule

bind sai_rx sai_rx_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o),
    .w_done  (w_done),
    .w_right (w_right)
);

// File: tb/sim_sai_rx.sv
module sim_sai_rx;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fmt_i2s = 1'b0;
    logic         lrclk = 1'b0;
    logic         sdata = 1'b0;
    logic [W-1:0] left_o;
    logic [W-1:0] right_o;
    logic         valid_o;

    sai_rx #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_i2s (fmt_i2s),
        .lrclk   (lrclk),
        .sdata   (sdata),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    always #5 clk = ~clk;

    int           n_chk = 0;
    int           n_fail = 0;
    logic         d_prev = 1'b0;
    logic [W-1:0] q_l[$];
    logic [W-1:0] q_r[$];
    string        q_t[$];

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic left_lvl();
        return fmt_i2s ? 1'b0 : 1'b1;
    endfunction

    function automatic logic [W-1:0] top_mask(int k);
        logic [W-1:0] m = '0;
        for (int i = 0; i < k && i < W; i++) m[W-1-i] = 1'b1;
        return m;
    endfunction

    // one bit slot; in I2S the data trails the frame clock by one slot
    task automatic put_slot(logic lr, logic d);
        @(negedge clk);
        lrclk = lr;
        if (fmt_i2s) begin
            sdata  = d_prev;
            d_prev = d;
        end else begin
            sdata = d;
        end
    endtask

    // slots past the word carry ones (don't-care junk)
    task automatic send_half(logic lr, logic [W-1:0] val, int slots, int nbits);
        for (int j = 0; j < slots; j++) begin
            logic b;
            if (j < nbits)  b = val[W-1-j];
            else if (j < W) b = 1'b0;
            else            b = 1'b1;
            put_slot(lr, b);
        end
    endtask

    task automatic send_frame(logic [W-1:0] l, logic [W-1:0] r, int slots, int nbits, string tag);
        int keep = (nbits < slots) ? nbits : slots;
        q_l.push_back(l & top_mask(keep));
        q_r.push_back(r & top_mask(keep));
        q_t.push_back(tag);
        send_half(left_lvl(), l, slots, nbits);
        send_half(~left_lvl(), r, slots, nbits);
    endtask

    task automatic start_seg(logic fmt, logic idle_left, int idle_slots);
        @(negedge clk);
        rst_n   = 1'b0;
        fmt_i2s = fmt;
        d_prev  = 1'b0;
        sdata   = 1'b0;
        lrclk   = idle_left ? left_lvl() : ~left_lvl();
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {{(W-1){1'b0}}, valid_o}, '0);
        check("R1 left in reset", left_o, '0);
        check("R1 right in reset", right_o, '0);
        rst_n = 1'b1;
        for (int k = 0; k < idle_slots; k++) put_slot(lrclk, idle_left);
    endtask

    task automatic end_seg(string tag);
        for (int k = 0; k < 4; k++) put_slot(left_lvl(), 1'b0);
        repeat (4) @(negedge clk);
        n_chk++;
        if (q_l.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing pulses actual=%0d expected=0", tag, q_l.size());
            q_l.delete(); q_r.delete(); q_t.delete();
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (q_l.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R8 unexpected pulse actual=1 expected=0");
            end else begin
                check({q_t[0], " left"}, left_o, q_l[0]);
                check({q_t[0], " right"}, right_o, q_r[0]);
                void'(q_l.pop_front());
                void'(q_r.pop_front());
                void'(q_t.pop_front());
            end
        end
    end

    logic finished = 1'b0;

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R2 R4 R5: MSB-justified, 32 slots per half, junk past slot 23
        start_seg(1'b0, 1'b0, 4);
        send_frame(24'hA5C3F1, 24'h5A3C0E, 32, 24, "R2 R4 R5 msb32");
        send_frame(24'h800000, 24'h7FFFFF, 32, 24, "R4 msb32 extremes");
        send_frame(24'h000001, 24'hFFFFFF, 32, 24, "R5 msb32 lsb");
        end_seg("R7 msb32");

        // R3 R5: I2S, 32 slots per half
        start_seg(1'b1, 1'b0, 4);
        send_frame(24'h123456, 24'hFEDCBA, 32, 24, "R3 R5 i2s32");
        send_frame(24'h800001, 24'h400002, 32, 24, "R3 i2s32 edges");
        send_frame(24'hC0FFEE, 24'h0BADF0, 32, 24, "R3 i2s32 mix");
        end_seg("R7 i2s32");

        // R9: exactly 24 slots per half, both framings
        start_seg(1'b0, 1'b0, 4);
        send_frame(24'h3C5A96, 24'hC3A569, 24, 24, "R9 msb24");
        send_frame(24'hFFFFFE, 24'h000003, 24, 24, "R9 msb24 b");
        end_seg("R9 msb24");
        start_seg(1'b1, 1'b0, 4);
        send_frame(24'h9ABCDE, 24'h654321, 24, 24, "R9 R3 i2s24 lsb next half");
        send_frame(24'h000001, 24'h800001, 24, 24, "R9 i2s24 b");
        end_seg("R9 i2s24");

        // R6: short senders and cut-short half-frames
        start_seg(1'b0, 1'b0, 4);
        send_frame(24'hABCDEF, 24'h13579B, 32, 16, "R6 msb 16-bit");
        send_frame(24'hFEDCBA, 24'h2468AC, 32, 20, "R6 msb 20-bit");
        send_frame(24'hFFFFFF, 24'hF0F0F7, 20, 24, "R6 msb cut short");
        send_frame(24'h7FFFFF, 24'h811111, 20, 24, "R6 msb cut short b");
        end_seg("R6 msb");
        start_seg(1'b1, 1'b0, 4);
        send_frame(24'hFFFFFF, 24'hA5A5A5, 20, 24, "R6 i2s cut short");
        send_frame(24'h876543, 24'h0FEDCB, 32, 20, "R6 i2s 20-bit");
        end_seg("R6 i2s");

        // R8 R10: partial half after reset and lone right word yield nothing
        start_seg(1'b0, 1'b1, 10);
        send_half(1'b0, 24'hDEAD01, 32, 24);
        send_frame(24'h112233, 24'h445566, 32, 24, "R8 R10 after lone right");
        send_frame(24'h778899, 24'hAABBCC, 32, 24, "R8 second pair");
        end_seg("R8 R10 msb");
        start_seg(1'b1, 1'b1, 10);
        send_half(1'b1, 24'hBEEF02, 32, 24);
        send_frame(24'hCAFE01, 24'hF00D02, 32, 24, "R8 R10 i2s after lone right");
        end_seg("R8 R10 i2s");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule